// File: doc/BRIEF.md
# Bit-Banged Serial Device Port

This block gives software direct control over the pins of a small serial device: one clock pin, one bidirectional data pin and three select pins. Software writes two registers to set each pin's direction and level. It then runs any serial protocol by toggling those bits. The block has no protocol sequencing of its own.

The clock pin has two output modes. In static mode it follows a register bit. In pulse mode it rests at the level of that bit and emits one pulse of the opposite level, lasting a fixed number of system clocks, each time the pin register is written. The select outputs drive the inverse of their register bits. Every pin is read back at its live pad level through a two-flop synchronizer, whatever its direction, so software can sample inputs and confirm what it drives.

Each pin has separate output-value and output-enable signals for a tristate pad. The pad level comes back in on a separate input.

Top module: `serdev_port`

## Requirements
- R1: After reset, the clock and select output enables are 0, the data pin drives low (`sdat_oe`=1, `sdat_o`=0), and the stored bits of both registers read as 0.
- R2: Control register (`wr_sel`=1): bit 4 drives `sck_oe`, and bits 1, 2 and 3 drive `ssel_oe[0]`, `ssel_oe[1]` and `ssel_oe[2]`. The write takes effect from the clock edge on which it is taken.
- R3: Pin register (`wr_sel`=0) with bit 3 (pulse mode) = 0: `sck_o` equals bit 2 from the write edge on.
- R4: With bit 3 = 1, `sck_o` rests at bit 2 and shows the inverse of bit 2 for exactly PULSE_LEN cycles, starting at the edge that takes each pin-register write.
- R5: A pin-register write that arrives during a pulse restarts it, so the pulse ends PULSE_LEN cycles after the last write.
- R6: Pin-register bit 1 = 0 makes the data pin an output (`sdat_oe`=1) that drives bit 0. Bit 1 = 1 makes it an input (`sdat_oe`=0).
- R7: `ssel_o[k]` is the inverse of pin-register bit 4+k, for k = 0..2.
- R8: A read of the pin register returns the synchronized pad levels, without inversion, at bit 0 (data), bit 2 (clock) and bits 4..6 (selects 0..2). Bits 1 and 3 return the stored bits and bit 7 returns 0. A pad change shows on `rd_data` two clock edges after it occurs.
- R9: A read of the control register returns the stored enables at bits 4..1 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 pin register, 1 control register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 pin register, 1 control register |
| rd_data | output | 8 | Read data |
| sck_o | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |
| sck_i | input | 1 | Clock pad level |
| sdat_o | output | 1 | Data pin output value |
| sdat_oe | output | 1 | Data pin output enable |
| sdat_i | input | 1 | Data pad level |
| ssel_o | output | 3 | Select pin output values |
| ssel_oe | output | 3 | Select pin output enables |
| ssel_i | input | 3 | Select pad levels |

## Verification
The bench loops each output back through a tristate pad model, with an external level that differs from the driven one. It sweeps every enable combination against every pin-register value. A design that read back the stored bit instead of the pad, or that inverted the select readback, would return the external level where the driven one is expected, or the reverse. The bench counts pulse cycles one by one, so a pulse that is one cycle short or long, or has the wrong polarity, fails. A second write placed in the middle of a pulse catches a counter that keeps running down instead of reloading.

// File: rtl/serdev_pkg.sv
package serdev_pkg;
  localparam int PIN_DAT   = 0;
  localparam int PIN_DDIR  = 1;
  localparam int PIN_SCK   = 2;
  localparam int PIN_PULSE = 3;
  localparam int PIN_SEL0  = 4;
  localparam int NSEL      = 3;
  localparam int CTL_SCKEN = 4;
  localparam int CTL_SEL0  = 1;
  localparam int NPAD      = 2 + NSEL;
endpackage

// File: rtl/serdev_sync.sv
module serdev_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/serdev_pulse.sv
module serdev_pulse #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOADV = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = fire || (cnt_q != '0);
    cnt_d  = fire ? LOADV : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/serdev_regs.sv
module serdev_regs
  import serdev_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [6:0] pin_q,
  output logic [4:1] ctl_q,
  output logic       pin_wr
);
  logic [6:0] pin_d;
  logic [4:1] ctl_d;
  logic       ctl_wr;

  always_comb begin
    pin_wr = wr_en && !wr_sel;
    ctl_wr = wr_en &&  wr_sel;
    pin_d  = wr_data[6:0];
    ctl_d  = wr_data[4:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= '0;
    else if (pin_wr) pin_q <= pin_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/serdev_port.sv
module serdev_port
  import serdev_pkg::*;
#(
  parameter int PULSE_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       sdat_o,
  output logic       sdat_oe,
  input  logic       sdat_i,
  output logic [2:0] ssel_o,
  output logic [2:0] ssel_oe,
  input  logic [2:0] ssel_i
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic [6:0]      pin_q;
  logic [4:1]      ctl_q;
  logic            pin_wr;
  logic            pulse_on;
  logic [NPAD-1:0] pad_raw, pad_s;

  serdev_regs u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pin_q(pin_q), .ctl_q(ctl_q), .pin_wr(pin_wr)
  );

  serdev_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_q), .fire(pin_wr), .active(pulse_on)
  );

  assign pad_raw = {ssel_i, sck_i, sdat_i};

  serdev_sync #(.W(NPAD)) u_sync (
    .clk(clk), .rst_n(rst_q), .d(pad_raw), .q(pad_s)
  );

  always_comb begin
    sck_oe  = ctl_q[CTL_SCKEN];
    sck_o   = pin_q[PIN_SCK] ^ (pin_q[PIN_PULSE] & pulse_on);
    sdat_oe = !pin_q[PIN_DDIR];
    sdat_o  = pin_q[PIN_DAT];
    for (int k = 0; k < NSEL; k++) begin
      ssel_oe[k] = ctl_q[CTL_SEL0 + k];
      ssel_o[k]  = !pin_q[PIN_SEL0 + k];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel) begin
      rd_data[4:1] = ctl_q;
    end else begin
      rd_data[PIN_DAT]   = pad_s[0];
      rd_data[PIN_DDIR]  = pin_q[PIN_DDIR];
      rd_data[PIN_SCK]   = pad_s[1];
      rd_data[PIN_PULSE] = pin_q[PIN_PULSE];
      rd_data[6:4]       = pad_s[4:2];
    end
  end
endmodule

// File: rtl/serdev_port_chk.sv
module serdev_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       sdat_o,
  input logic       sdat_oe,
  input logic [2:0] ssel_o,
  input logic [2:0] ssel_oe
);
  p_ctl_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (sck_oe == $past(wr_data[4])) && (ssel_oe == $past(wr_data[3:1])));

  p_static_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !wr_data[3]) |=> (sck_o == $past(wr_data[2])));

  p_pulse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[3]) |=> (sck_o == !$past(wr_data[2])));

  p_data_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (sdat_oe == !$past(wr_data[1])) && (sdat_o == $past(wr_data[0])));

  p_sel_invert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (ssel_o == ~$past(wr_data[6:4])));

  p_no_ctl_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_sel)) |=> $stable(sck_oe) && $stable(ssel_oe));
endmodule

bind serdev_port serdev_port_chk u_chk (
  .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .sck_o(sck_o), .sck_oe(sck_oe), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
  .ssel_o(ssel_o), .ssel_oe(ssel_oe)
);

// File: tb/serdev_port_test.sv
module serdev_port_test;
  localparam int P = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sck_o, sck_oe, sdat_o, sdat_oe;
  logic [2:0] ssel_o, ssel_oe;
  logic [4:0] ext = '0;  // external levels: {sel2,sel1,sel0,sck,dat}
  logic       sck_i, sdat_i;
  logic [2:0] ssel_i;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  assign sdat_i = sdat_oe ? sdat_o : ext[0];
  assign sck_i  = sck_oe  ? sck_o  : ext[1];
  for (genvar k = 0; k < 3; k++) begin : g_pad
    assign ssel_i[k] = ssel_oe[k] ? ssel_o[k] : ext[2+k];
  end

  serdev_port #(.PULSE_LEN(P)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i),
    .ssel_o(ssel_o), .ssel_oe(ssel_oe), .ssel_i(ssel_i)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // write on the next edge; returns at the negedge after that edge
  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] lvl;
    logic [7:0] exp;
    idle(2);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 sck_oe", {7'd0, sck_oe}, 8'd0);
    chk("R1 ssel_oe", {5'd0, ssel_oe}, 8'd0);
    chk("R1 data drive", {6'd0, sdat_oe, sdat_o}, 8'b10);
    rd_sel = 1'b1; #1;
    chk("R1 ctl read", rd_data, 8'd0);
    rd_sel = 1'b0; #1;
    chk("R1 pin read stored", rd_data & 8'h8A, 8'd0);

    for (int c = 0; c < 16; c++) begin
      wr(1'b1, 8'(c << 1));
      chk("R2 sck_oe", {7'd0, sck_oe}, {7'd0, c[3]});
      chk("R2 ssel_oe", {5'd0, ssel_oe}, {5'd0, c[2:0]});
      for (int v = 0; v < 128; v++) begin
        ext = 5'(v * 7 + c) ^ 5'h15;
        wr(1'b0, 8'(v));
        chk("R6 data", {6'd0, sdat_oe, sdat_o}, {6'd0, ~v[1], v[0]});
        chk("R7 select", {5'd0, ssel_o}, {5'd0, ~v[6:4]});
        if (v[3]) begin
          for (int t = 0; t < P; t++) begin
            chk("R4 pulse", {7'd0, sck_o}, {7'd0, ~v[2]});
            @(negedge clk);
          end
          chk("R4 rest", {7'd0, sck_o}, {7'd0, v[2]});
        end else begin
          chk("R3 static", {7'd0, sck_o}, {7'd0, v[2]});
          idle(P);
          chk("R3 hold", {7'd0, sck_o}, {7'd0, v[2]});
        end
        idle(2);
        lvl[0] = ~v[1] ? v[0] : ext[0];
        lvl[1] = c[3] ? v[2] : ext[1];
        for (int k = 0; k < 3; k++) lvl[2+k] = c[k] ? ~v[4+k] : ext[2+k];
        exp = {1'b0, lvl[4:2], v[3], lvl[1], v[1], lvl[0]};
        rd_sel = 1'b0; #1;
        chk("R8 pin readback", rd_data, exp);
        rd_sel = 1'b1; #1;
        chk("R9 ctl readback", rd_data, {3'd0, c[3:0], 1'b0});
        rd_sel = 1'b0;
      end
    end

    // R5 restart: two writes on consecutive edges
    wr(1'b1, 8'h10);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h08;
    @(negedge clk);
    chk("R5 first pulse", {7'd0, sck_o}, 8'd1);
    @(negedge clk);
    wr_en = 1'b0;
    for (int t = 0; t < P; t++) begin
      chk("R5 restarted pulse", {7'd0, sck_o}, 8'd1);
      @(negedge clk);
    end
    chk("R5 end", {7'd0, sck_o}, 8'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule